// File: doc/BRIEF.md
# Colour Subcarrier Phase Synthesiser

This block produces the phase word of a colour subcarrier for a video encoder. A 24-bit accumulator advances by a programmable increment on every pixel clock. The output is the accumulator plus a programmable phase offset plus a signed hue adjustment, all taken modulo 2^24. The word is meant to address a sine/cosine lookup downstream.

The increment and offset are written a byte at a time into staging registers. A preset strobe can instead load the values for a chosen video standard. Staged values take effect only when the oscillator is re-synchronised. A re-synchronisation clears the accumulator and copies the staged values into the running copies, so the phase never jumps in the middle of a line. Re-synchronisation comes from a periodic cadence (every line, or every 2nd, 4th or 8th field) or from a reset flag carried by an external colour-frequency-control word. The hue adjustment is sign-magnitude and is applied at once, without waiting for a re-synchronisation.

Top module: `subcarrier_dds`

## Requirements
- R1: While `rstN` is low, `phaseOut` is 0. After reset, both the staged and the running increment/offset hold the NTSC preset (increment 0x21F07C, offset 0x1FC000) and the accumulator is 0. With `hue` = 0, the first `phaseOut` after reset is 0x1FC000 and the next is 0x1FC000 + 0x21F07C.
- R2: `phaseOut` is registered. The value after a clock edge equals (accumulator before that edge + running offset + hue term of `hue` at that edge) mod 2^24. Without a re-synchronisation, the accumulator grows by the running increment at every edge.
- R3: When `incWrEn` or `offWrEn` is high, `wrData` is written into one byte of the staged increment or staged offset. `byteSel` 0 selects bits 7:0, 1 selects bits 15:8 and 2 selects bits 23:16. `byteSel` 3 writes nothing. Staged values do not change the running values until the next re-synchronisation.
- R4: A `stdLoad` pulse loads both staged registers from `stdSel`. Code 0 gives NTSC (0x21F07C, 0x1FC000), code 1 gives PAL (0x2A098B, 0xD9C000) and code 2 gives blue-line (0x21F07C, 0). Code 3 leaves the staged values unchanged. When `stdLoad` and a byte write fall in the same cycle, the preset wins.
- R5: With `autoRstEn` high and `cadenceSel` = 0, a `lineStart` pulse sampled at edge k re-synchronises at edge k+1. The accumulator is cleared and the staged values go live at that edge, so the `phaseOut` after edge k+2 equals new offset + hue term.
- R6: `cadenceSel` codes 1, 2 and 3 re-synchronise on every 2nd, 4th and 8th `fieldStart` pulse. The pulses are counted from reset, a 3-bit counter counts every pulse whether or not `autoRstEn` is high, and a pulse fires when the counter's low 1, 2 or 3 bits are all ones. The timing is the same as in R5.
- R7: With `cfcRstEn` high, a `cfcWordLoad` pulse with `cfcRstBit` high re-synchronises one clock later, with the same timing as R5.
- R8: The hue term is the 7-bit magnitude `hue[6:0]` shifted left by 13, so one LSB is 360/2048 degrees. `hue[7]` = 1 adds the term and 0 subtracts it. A magnitude of 0 adds nothing with either sign.
- R9: With `autoRstEn` low, `lineStart` and `fieldStart` cause no re-synchronisation. With `cfcRstEn` low, the control word causes none. In a field cadence, `lineStart` causes none.
- R10: All phase arithmetic wraps modulo 2^24. The accumulator and the output roll over with no saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrData | input | 8 | Byte to write into staged increment/offset |
| byteSel | input | 2 | Byte lane of the write (0 low, 2 high, 3 none) |
| incWrEn | input | 1 | Write strobe for staged increment |
| offWrEn | input | 1 | Write strobe for staged offset |
| stdLoad | input | 1 | Load standard preset into staging |
| stdSel | input | 2 | Standard code for preset |
| autoRstEn | input | 1 | Enable periodic re-synchronisation |
| cadenceSel | input | 2 | 0 line, 1/2/3 every 2/4/8 fields |
| lineStart | input | 1 | Line start pulse |
| fieldStart | input | 1 | Field start pulse |
| cfcRstEn | input | 1 | Enable control-word re-synchronisation |
| cfcWordLoad | input | 1 | Pulse: low bit of a control word has been loaded |
| cfcRstBit | input | 1 | Reset flag of that control word |
| hue | input | 8 | Sign-magnitude hue adjustment |
| phaseOut | output | 24 | Subcarrier phase word |

## Verification
The hardest situation to reach is an 8-field re-synchronisation while other traffic is under way. It needs a field counter phase that can only be observed through the time at which the output phase resets, and it has to fall together with staged writes that must stay hidden until that event. The stimulus first walks each field cadence through a directed run of field pulses, checking that the output keeps advancing by the increment until the expected pulse. It then runs a long seeded random mix of field and line pulses, byte writes, presets, control words and hue changes, compared every cycle with a bench reference model.

// File: rtl/scdds_pkg.sv
package scdds_pkg;
  localparam int AccW     = 24;
  localparam int ByteW    = 8;
  localparam int ByteCnt  = AccW / ByteW;
  localparam int SelW     = 2;

  typedef logic [AccW-1:0] phase_t;

  typedef enum logic [1:0] {
    STD_NTSC = 2'd0,
    STD_PAL  = 2'd1,
    STD_BLUE = 2'd2,
    STD_KEEP = 2'd3
  } std_e;

  typedef enum logic [1:0] {
    CAD_LINE   = 2'd0,
    CAD_FIELD2 = 2'd1,
    CAD_FIELD4 = 2'd2,
    CAD_FIELD8 = 2'd3
  } cadence_e;

  typedef struct packed {
    logic               phaseRst;
    logic               presetLoad;
    std_e               presetStd;
    logic [ByteCnt-1:0] incByteWe;
    logic [ByteCnt-1:0] offByteWe;
  } ddsCtl_t;

  localparam phase_t NtscInc = 24'h21F07C;
  localparam phase_t NtscOff = 24'h1FC000;
  localparam phase_t PalInc  = 24'h2A098B;
  localparam phase_t PalOff  = 24'hD9C000;
  localparam phase_t BlueOff = 24'h000000;

  function automatic phase_t presetInc(std_e s, phase_t cur);
    case (s)
      STD_NTSC, STD_BLUE: presetInc = NtscInc;
      STD_PAL:            presetInc = PalInc;
      default:            presetInc = cur;
    endcase
  endfunction

  function automatic phase_t presetOff(std_e s, phase_t cur);
    case (s)
      STD_NTSC: presetOff = NtscOff;
      STD_PAL:  presetOff = PalOff;
      STD_BLUE: presetOff = BlueOff;
      default:  presetOff = cur;
    endcase
  endfunction
endpackage

// File: rtl/scdds_ctrl.sv
module scdds_ctrl
  import scdds_pkg::*;
#(
  parameter int FieldCntW = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [SelW-1:0] byteSel,
  input  logic            incWrEn,
  input  logic            offWrEn,
  input  logic            stdLoad,
  input  logic [1:0]      stdSel,
  input  logic            autoRstEn,
  input  logic [1:0]      cadenceSel,
  input  logic            lineStart,
  input  logic            fieldStart,
  input  logic            cfcRstEn,
  input  logic            cfcWordLoad,
  input  logic            cfcRstBit,
  output ddsCtl_t         ctl
);
  logic [FieldCntW-1:0] fieldCnt;
  logic [FieldCntW-1:0] fieldMask;
  logic                 lineHit, fieldHit, cfcHit, rstPend;
  logic [ByteCnt-1:0]   incWe, offWe;
  cadence_e             cad;

  assign cad = cadence_e'(cadenceSel);

  always_comb begin
    fieldMask = '0;
    case (cad)
      CAD_FIELD2: fieldMask = FieldCntW'(1);
      CAD_FIELD4: fieldMask = FieldCntW'(3);
      CAD_FIELD8: fieldMask = FieldCntW'(7);
      default:    fieldMask = '0;
    endcase
  end

  assign lineHit  = autoRstEn && (cad == CAD_LINE) && lineStart;
  assign fieldHit = autoRstEn && (cad != CAD_LINE) && fieldStart &&
                    ((fieldCnt & fieldMask) == fieldMask);
  assign cfcHit   = cfcRstEn && cfcWordLoad && cfcRstBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fieldCnt <= '0;
      rstPend  <= 1'b0;
    end else begin
      if (fieldStart) fieldCnt <= fieldCnt + 1'b1;
      rstPend <= lineHit || fieldHit || cfcHit;
    end
  end

  for (genvar b = 0; b < ByteCnt; b++) begin : g_lane
    assign incWe[b] = incWrEn && (byteSel == SelW'(b));
    assign offWe[b] = offWrEn && (byteSel == SelW'(b));
  end

  always_comb begin
    ctl            = '0;
    ctl.phaseRst   = rstPend;
    ctl.presetLoad = stdLoad;
    ctl.presetStd  = std_e'(stdSel);
    ctl.incByteWe  = incWe;
    ctl.offByteWe  = offWe;
  end

  // R5: line cadence re-synchronises one cycle after the pulse
  assert_line_latency_R5: assert property (@(posedge clk) disable iff (!rstN)
    (autoRstEn && cadenceSel == 2'd0 && lineStart) |=> ctl.phaseRst);

  // R7: control-word reset flag acts one cycle later
  assert_cfc_latency_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cfcRstEn && cfcWordLoad && cfcRstBit) |=> ctl.phaseRst);

  // R9: no re-synchronisation without a pulse on some source
  assert_has_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.phaseRst |-> $past(lineStart || fieldStart || cfcWordLoad));

  // R9: with every source disabled nothing fires
  assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!autoRstEn && !cfcRstEn) |=> !ctl.phaseRst);
endmodule

// File: rtl/scdds_datapath.sv
module scdds_datapath
  import scdds_pkg::*;
#(
  parameter int HueW        = 8,
  parameter int HueStepBits = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  ddsCtl_t          ctl,
  input  logic [ByteW-1:0] wrData,
  input  logic [HueW-1:0]  hue,
  output phase_t           phaseOut
);
  localparam int HueShift = AccW - HueStepBits;
  localparam int MagW     = HueW - 1;

  phase_t stagedInc, stagedOff, activeInc, activeOff, acc, phaseQ;
  phase_t nextInc, nextOff, presetIncVal, presetOffVal;
  phase_t hueMag, hueTerm;

  assign presetIncVal = presetInc(ctl.presetStd, stagedInc);
  assign presetOffVal = presetOff(ctl.presetStd, stagedOff);

  for (genvar b = 0; b < ByteCnt; b++) begin : g_stage
    assign nextInc[b*ByteW +: ByteW] =
      ctl.presetLoad   ? presetIncVal[b*ByteW +: ByteW] :
      ctl.incByteWe[b] ? wrData : stagedInc[b*ByteW +: ByteW];
    assign nextOff[b*ByteW +: ByteW] =
      ctl.presetLoad   ? presetOffVal[b*ByteW +: ByteW] :
      ctl.offByteWe[b] ? wrData : stagedOff[b*ByteW +: ByteW];
  end

  assign hueMag  = phase_t'(hue[MagW-1:0]) << HueShift;
  assign hueTerm = hue[HueW-1] ? hueMag : (phase_t'(0) - hueMag);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stagedInc <= NtscInc;
      stagedOff <= NtscOff;
      activeInc <= NtscInc;
      activeOff <= NtscOff;
      acc       <= '0;
      phaseQ    <= '0;
    end else begin
      stagedInc <= nextInc;
      stagedOff <= nextOff;
      phaseQ    <= acc + activeOff + hueTerm;
      if (ctl.phaseRst) begin
        acc       <= '0;
        activeInc <= stagedInc;
        activeOff <= stagedOff;
      end else begin
        acc <= acc + activeInc;
      end
    end
  end

  assign phaseOut = phaseQ;

  // R3: running values only move on a re-synchronisation
  assert_hold_active_R3: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.phaseRst |=> ($stable(activeInc) && $stable(activeOff)));

  // R5: accumulator restarts from zero after a re-synchronisation
  assert_acc_cleared_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.phaseRst |=> (acc == '0));

  // R2: output follows accumulator, offset and hue of the previous cycle
  assert_output_sum_R2: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (phaseOut == $past(acc + activeOff + hueTerm)));
endmodule

// File: rtl/subcarrier_dds.sv
module subcarrier_dds
  import scdds_pkg::*;
#(
  parameter int HueW        = 8,
  parameter int HueStepBits = 11,
  parameter int FieldCntW   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        wrData,
  input  logic [1:0]        byteSel,
  input  logic              incWrEn,
  input  logic              offWrEn,
  input  logic              stdLoad,
  input  logic [1:0]        stdSel,
  input  logic              autoRstEn,
  input  logic [1:0]        cadenceSel,
  input  logic              lineStart,
  input  logic              fieldStart,
  input  logic              cfcRstEn,
  input  logic              cfcWordLoad,
  input  logic              cfcRstBit,
  input  logic [HueW-1:0]   hue,
  output logic [23:0]       phaseOut
);
  ddsCtl_t ctl;
  phase_t  phaseW;

  scdds_ctrl #(.FieldCntW(FieldCntW)) ctrl_i (
    .clk(clk), .rstN(rstN), .byteSel(byteSel), .incWrEn(incWrEn),
    .offWrEn(offWrEn), .stdLoad(stdLoad), .stdSel(stdSel),
    .autoRstEn(autoRstEn), .cadenceSel(cadenceSel), .lineStart(lineStart),
    .fieldStart(fieldStart), .cfcRstEn(cfcRstEn), .cfcWordLoad(cfcWordLoad),
    .cfcRstBit(cfcRstBit), .ctl(ctl)
  );

  scdds_datapath #(.HueW(HueW), .HueStepBits(HueStepBits)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrData(wrData), .hue(hue),
    .phaseOut(phaseW)
  );

  assign phaseOut = phaseW;
endmodule

// File: tb/subcarrier_dds_tb_top.sv
module subcarrier_dds_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN;
  logic [7:0] wrData, hue;
  logic [1:0] byteSel, stdSel, cadenceSel;
  logic incWrEn, offWrEn, stdLoad, autoRstEn, lineStart, fieldStart;
  logic cfcRstEn, cfcWordLoad, cfcRstBit;
  logic [23:0] phaseOut;

  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R2";

  subcarrier_dds dut_i (
    .clk(clk), .rstN(rstN), .wrData(wrData), .byteSel(byteSel),
    .incWrEn(incWrEn), .offWrEn(offWrEn), .stdLoad(stdLoad), .stdSel(stdSel),
    .autoRstEn(autoRstEn), .cadenceSel(cadenceSel), .lineStart(lineStart),
    .fieldStart(fieldStart), .cfcRstEn(cfcRstEn), .cfcWordLoad(cfcWordLoad),
    .cfcRstBit(cfcRstBit), .hue(hue), .phaseOut(phaseOut)
  );

  // reference model built from the requirements
  logic [23:0] mStgInc, mStgOff, mActInc, mActOff, mAcc, mPhase;
  logic [2:0]  mField;
  logic        mRst;

  function automatic logic [23:0] hueOf(logic [7:0] h);
    logic [23:0] m;
    m = {10'd0, h[6:0], 7'd0} << 6;
    return h[7] ? m : (24'd0 - m);
  endfunction

  function automatic logic [2:0] maskOf(logic [1:0] c);
    return (c == 2'd1) ? 3'd1 : (c == 2'd2) ? 3'd3 : (c == 2'd3) ? 3'd7 : 3'd0;
  endfunction

  always @(posedge clk) begin
    logic hit;
    logic [23:0] ni, no;
    if (!rstN) begin
      mStgInc <= 24'h21F07C; mStgOff <= 24'h1FC000;
      mActInc <= 24'h21F07C; mActOff <= 24'h1FC000;
      mAcc <= 0; mPhase <= 0; mField <= 0; mRst <= 0;
    end else begin
      mPhase <= mAcc + mActOff + hueOf(hue);
      if (mRst) begin
        mAcc <= 0; mActInc <= mStgInc; mActOff <= mStgOff;
      end else mAcc <= mAcc + mActInc;
      ni = mStgInc; no = mStgOff;
      if (stdLoad) begin
        case (stdSel)
          2'd0: begin ni = 24'h21F07C; no = 24'h1FC000; end
          2'd1: begin ni = 24'h2A098B; no = 24'hD9C000; end
          2'd2: begin ni = 24'h21F07C; no = 24'h000000; end
          default: ;
        endcase
      end else if (byteSel != 2'd3) begin
        if (incWrEn) ni[byteSel*8 +: 8] = wrData;
        if (offWrEn) no[byteSel*8 +: 8] = wrData;
      end
      mStgInc <= ni; mStgOff <= no;
      hit = (cfcRstEn && cfcWordLoad && cfcRstBit) ||
            (autoRstEn && cadenceSel == 2'd0 && lineStart) ||
            (autoRstEn && cadenceSel != 2'd0 && fieldStart &&
             ((mField & maskOf(cadenceSel)) == maskOf(cadenceSel)));
      mRst <= hit;
      if (fieldStart) mField <= mField + 3'd1;
    end
  end

  task automatic chk(string t, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: phaseOut=%h expected=%h at %0t", t, act, exp, $time);
    end
  endtask

  // one clock; compare against model at the falling edge
  task automatic step();
    @(negedge clk);
    chk(tag, phaseOut, mPhase);
    lineStart = 0; fieldStart = 0; cfcWordLoad = 0; stdLoad = 0;
    incWrEn = 0; offWrEn = 0;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [23:0] p0, p1;
    void'($urandom(32'd1234));
    rstN = 0; wrData = 0; hue = 0; byteSel = 0; stdSel = 0; cadenceSel = 0;
    incWrEn = 0; offWrEn = 0; stdLoad = 0; autoRstEn = 0; lineStart = 0;
    fieldStart = 0; cfcRstEn = 0; cfcWordLoad = 0; cfcRstBit = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset output", phaseOut, 24'h0);
    rstN = 1;
    @(negedge clk); chk("R1 first phase", phaseOut, 24'h1FC000);
    @(negedge clk); chk("R1 second phase", phaseOut, 24'h1FC000 + 24'h21F07C);
    tag = "R2 free run"; run(20);

    // R3: staged bytes hidden until event; lane 3 ignored
    tag = "R3 staging";
    p0 = phaseOut;
    wrData = 8'h11; byteSel = 0; incWrEn = 1; step();
    wrData = 8'h22; byteSel = 1; incWrEn = 1; step();
    wrData = 8'h03; byteSel = 2; incWrEn = 1; offWrEn = 1; step();
    wrData = 8'hFF; byteSel = 3; incWrEn = 1; offWrEn = 1; step();
    p1 = phaseOut; step();
    chk("R3 old increment kept", phaseOut - p1, 24'h21F07C);
    autoRstEn = 1; cadenceSel = 0; lineStart = 1; step(); step();
    @(negedge clk); chk("R3 R5 restart offset", phaseOut, 24'h03C000);
    step(); chk("R3 new increment", phaseOut - 24'h03C000, 24'h032211);
    tag = "R5 line"; run(10);

    // R4: presets, priority over write
    tag = "R4 preset";
    stdLoad = 1; stdSel = 1; incWrEn = 1; byteSel = 0; wrData = 8'hAA; step();
    lineStart = 1; step(); step();
    @(negedge clk); chk("R4 PAL offset", phaseOut, 24'hD9C000);
    step(); chk("R4 PAL increment", phaseOut - 24'hD9C000, 24'h2A098B);
    stdLoad = 1; stdSel = 2; step(); lineStart = 1; step(); step();
    @(negedge clk); chk("R4 blue offset", phaseOut, 24'h0);
    stdLoad = 1; stdSel = 3; step(); lineStart = 1; step(); step();
    @(negedge clk); chk("R4 keep code", phaseOut, 24'h0);
    stdLoad = 1; stdSel = 0; step(); run(5);

    // R8: hue
    tag = "R8 hue";
    hue = 8'h7F; step(); p0 = phaseOut; hue = 8'hFF; step();
    chk("R8 sign flip delta", phaseOut - p0 - 24'h21F07C, {7'h7F, 13'd0} + {7'h7F, 13'd0});
    hue = 8'h80; run(3); hue = 8'h00; run(3); hue = 8'h81; run(3);

    // R9: disabled sources ignored
    tag = "R9 disabled";
    autoRstEn = 0; cfcRstEn = 0;
    for (int i = 0; i < 6; i++) begin
      lineStart = 1; fieldStart = 1; cfcWordLoad = 1; cfcRstBit = 1;
      p0 = phaseOut; step();
      chk("R9 no restart", phaseOut - p0, 24'h21F07C);
    end
    autoRstEn = 1; cadenceSel = 2; lineStart = 1; step(); run(4);

    // R6: field cadences
    for (int c = 1; c < 4; c++) begin
      cadenceSel = c[1:0];
      tag = "R6 field cadence";
      for (int k = 0; k < 12; k++) begin fieldStart = 1; step(); run(3); end
    end

    // R7: control word
    autoRstEn = 0; cfcRstEn = 1; tag = "R7 cfc";
    cfcWordLoad = 1; cfcRstBit = 0; step(); run(3);
    cfcWordLoad = 1; cfcRstBit = 1; step(); step();
    @(negedge clk); chk("R7 cfc restart", phaseOut, 24'h1FC000 + hueOf(hue));
    run(4);

    // R10: wrap with large increment
    tag = "R10 wrap";
    hue = 0; offWrEn = 1; incWrEn = 1; wrData = 8'hFF; byteSel = 2; step();
    cfcWordLoad = 1; cfcRstBit = 1; step(); run(12);

    // random mix
    tag = "R2 R6 random";
    for (int i = 0; i < 6000; i++) begin
      autoRstEn   = ($urandom % 8) != 0;
      cfcRstEn    = $urandom % 2;
      cadenceSel  = $urandom % 4;
      lineStart   = ($urandom % 16) == 0;
      fieldStart  = ($urandom % 24) == 0;
      cfcWordLoad = ($urandom % 20) == 0;
      cfcRstBit   = $urandom % 2;
      incWrEn     = ($urandom % 12) == 0;
      offWrEn     = ($urandom % 12) == 0;
      byteSel     = $urandom % 4;
      wrData      = $urandom % 256;
      stdLoad     = ($urandom % 64) == 0;
      stdSel      = $urandom % 4;
      if (($urandom % 32) == 0) hue = $urandom % 256;
      @(negedge clk);
      chk(tag, phaseOut, mPhase);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule